// File: doc/BRIEF.md
# SD Command Sequencer

This block issues a single command to an SD card over the CMD line and collects the card's reply. Software loads an argument, a command index, a setting word, a timeout and a clock divider through a small register port, then writes the start register. The engine assembles a 48-bit command frame with its CRC7, shifts it out on a divided SD clock, then listens for the reply's start bit within the timeout. It captures a 48-bit or 136-bit reply, checks the reply CRC and records how many SD clocks it waited.

After each command, diagnostics can be read back: the exact frame that went out, the measured wait, and copies of every control register that trail the live registers by one clock. The data lines and their buffers are outside this block.

Top module: `sd_cmd_seq`

## Requirements
- R1: The frame is, MSB first: start bit 0, transmission bit 1, 6-bit command index, 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed, over the first 40 bits), end bit 1. After a start it reads back at 0x18 (frame bits 31:0) and 0x1C (bits 47:32 in bits 15:0).
- R2: The SD clock is low when idle and, while busy, has a period of 2*(div+1) system clocks, with div taken from the control register at 0x20. The CMD output is driven (output enable high) only during the frame and changes only on a falling SD clock edge.
- R3: With setting bit 0 clear (no response), the command completes once the end bit has been sent. Status (0x14) then reads 0x2: bit 0 busy, bit 1 done, bit 2 timeout, bit 3 response CRC error.
- R4: With setting bit 0 set and bit 1 clear, a 48-bit reply is captured on rising SD clock edges, starting with the first 0 seen on CMD. The reply reads back at 0x00 (bits 38:7), 0x04 (70:39), 0x08 (102:71) and 0x0C (133:103), with unused upper bits zero.
- R5: With setting bits 1:0 both set, a 136-bit reply is captured and read back through the same four words.
- R6: The wait register (0x10) holds the number of rising SD clock edges that sampled CMD high after the frame ended and before the reply's start bit.
- R7: If the timeout register (0x1C write) value T is reached with CMD still high on the T-th rising edge, the command ends with status 0x4 and wait = T. Done and timeout are never set together. Both stay set until the next start.
- R8: The reply CRC7 covers reply bits 47:8 for a short reply and 127:8 for a long one, and is compared with bits 7:1. A mismatch sets status bit 3 together with done.
- R9: A write of 1 to the start register (0x0C) while busy is ignored: the frame and the command in flight are unchanged.
- R10: Writing 1 to the reset register (0x10) aborts a command. Busy, done, timeout and CRC error clear, the CMD output is released and the SD clock stops.
- R11: Each of the nine control registers (write offsets 0x00 argument, 0x04 index, 0x08 setting, 0x0C start, 0x10 reset, 0x14 block count, 0x18 block size, 0x1C timeout, 0x20 divider) reads back at its offset plus 0x40, one clock after the live register.
- R12: A read of any other address returns 0xDEADBEEF.
- R13: After reset, status, wait, frame and reply words read 0, the SD clock is low and the CMD output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| sd_clk_o | output | 1 | Divided SD clock |
| sd_cmd_o | output | 1 | CMD line output value |
| sd_cmd_oe_o | output | 1 | CMD output enable |
| sd_cmd_i | input | 1 | CMD line input value |

## Verification
Commands are run with no reply, short replies with good and corrupted CRC, a long reply, and a silent card. Together these separate the completion paths, the capture length and word mapping, and the CRC comparison. Divider values 0, 1 and 2 show that the wait is counted in SD clocks and not in system clocks, and the wire capture shows the bit order against the read-back frame. A second start during a pending command and an abort partway through a long wait test the two paths that interrupt the normal sequence, and a one-clock read-back probe tests the delayed copies.

// File: rtl/sd_cmd_seq_pkg.sv
package sd_cmd_seq_pkg;
  localparam int FRAME_W = 48;
  localparam int RSP_W   = 136;
  localparam int SHORT_W = 48;
  localparam int NCTL    = 9;

  localparam int CTL_ARG   = 0;
  localparam int CTL_IDX   = 1;
  localparam int CTL_SET   = 2;
  localparam int CTL_START = 3;
  localparam int CTL_RST   = 4;
  localparam int CTL_BCNT  = 5;
  localparam int CTL_BSIZE = 6;
  localparam int CTL_TMO   = 7;
  localparam int CTL_DIV   = 8;

  localparam logic [31:0] UNUSED_WORD = 32'hDEAD_BEEF;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_DATA} rx_state_e;

  function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [5:0] idx,
                                                      input logic [31:0] arg);
    logic [39:0] body;
    logic [6:0]  c;
    body = {2'b01, idx, arg};
    c    = '0;
    for (int i = 39; i >= 0; i--) c = crc7_next(c, body[i]);
    return {body, c, 1'b1};
  endfunction
endpackage

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sd_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             wrap;

  assign wrap = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_o   = wrap && !clk_q;
  assign fall_o   = wrap && clk_q;
  assign sd_clk_o = clk_q;

  AST_CLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sd_clk_o); // R2
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               abort_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               fall_i,
  output logic               cmd_o,
  output logic               oe_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               act_q;

  assign done_o = act_q && fall_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (abort_i) begin
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q && fall_i) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cmd_o = act_q ? sh_q[FRAME_W-1] : 1'b1;
  assign oe_o  = act_q;

  AST_TX_HOLD_BETWEEN_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !fall_i && !abort_i) |=> $stable(cmd_o)); // R2
  AST_TX_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !abort_i) |=> (oe_o && !cmd_o)); // R1
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
  import sd_cmd_seq_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             arm_i,
  input  logic             abort_i,
  input  logic             long_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             rise_i,
  input  logic             cmd_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic             crc_bad_o,
  output logic [RSP_W-1:0] rsp_o,
  output logic [TMO_W-1:0] wait_o
);
  localparam int CNT_W = $clog2(RSP_W);
  localparam logic [CNT_W-1:0] S_LAST   = CNT_W'(SHORT_W - 1);
  localparam logic [CNT_W-1:0] L_LAST   = CNT_W'(RSP_W - 1);
  localparam logic [CNT_W-1:0] S_CRC_HI = CNT_W'(SHORT_W - 9);
  localparam logic [CNT_W-1:0] L_CRC_LO = CNT_W'(RSP_W - 128);
  localparam logic [CNT_W-1:0] L_CRC_HI = CNT_W'(RSP_W - 9);

  rx_state_e        st_q;
  logic [RSP_W-1:0] rsp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       crc_q;
  logic [TMO_W-1:0] wait_q;
  logic             long_q;
  logic             capture, in_crc;
  logic [CNT_W-1:0] last_idx;
  logic [TMO_W-1:0] wait_nx;

  assign capture  = rise_i && (((st_q == RX_WAIT) && !cmd_i) || (st_q == RX_DATA));
  assign last_idx = long_q ? L_LAST : S_LAST;
  assign in_crc   = long_q ? ((cnt_q >= L_CRC_LO) && (cnt_q <= L_CRC_HI))
                           : (cnt_q <= S_CRC_HI);
  assign wait_nx  = wait_q + 1'b1;

  assign done_o    = (st_q == RX_DATA) && rise_i && (cnt_q == last_idx);
  assign tmo_o     = (st_q == RX_WAIT) && rise_i && cmd_i && (wait_nx >= timeout_i);
  assign crc_bad_o = done_o && (crc_q != rsp_q[6:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      rsp_q  <= '0;
      cnt_q  <= '0;
      crc_q  <= '0;
      wait_q <= '0;
      long_q <= 1'b0;
    end else if (abort_i) begin
      st_q <= RX_IDLE;
    end else begin
      if (clr_i) begin
        rsp_q  <= '0;
        wait_q <= '0;
      end
      if (arm_i) begin
        st_q   <= RX_WAIT;
        cnt_q  <= '0;
        crc_q  <= '0;
        long_q <= long_i;
      end else begin
        if (capture) begin
          rsp_q <= {rsp_q[RSP_W-2:0], cmd_i};
          cnt_q <= cnt_q + 1'b1;
          if (in_crc) crc_q <= crc7_next(crc_q, cmd_i);
        end
        case (st_q)
          RX_WAIT: if (rise_i) begin
            if (!cmd_i) st_q <= RX_DATA;
            else begin
              wait_q <= wait_nx;
              if (tmo_o) st_q <= RX_IDLE;
            end
          end
          RX_DATA: if (done_o) st_q <= RX_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign rsp_o  = rsp_q;
  assign wait_o = wait_q;

  AST_RX_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && tmo_o)); // R7
  AST_RX_WAIT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_DATA) |=> $stable(wait_o)); // R6
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sd_clk_o,
  output logic              sd_cmd_o,
  output logic              sd_cmd_oe_o,
  input  logic              sd_cmd_i
);
  localparam int RB_WORD = 16;

  logic [31:0] ctl_q   [NCTL];
  logic [31:0] ctl_dly [NCTL];
  logic [FRAME_W-1:0] frame_q, frame_w;
  logic busy_q, done_q, tmo_q, crcerr_q, resp_en_q, long_q;
  logic start_req, abort_req, launch, finish;
  logic rise, fall, tx_done, rx_done, rx_tmo, rx_crc_bad;
  logic [RSP_W-1:0] rsp;
  logic [TMO_W-1:0] wait_cnt;
  logic [ADDR_W-3:0] word;

  assign word      = reg_addr_i[ADDR_W-1:2];
  assign start_req = reg_we_i && (word == (ADDR_W-2)'(CTL_START)) && reg_wdata_i[0];
  assign abort_req = reg_we_i && (word == (ADDR_W-2)'(CTL_RST)) && reg_wdata_i[0];
  assign launch    = start_req && !busy_q && !abort_req;
  assign finish    = (tx_done && !resp_en_q) || rx_done || rx_tmo;
  assign frame_w   = build_frame(ctl_q[CTL_IDX][5:0], ctl_q[CTL_ARG]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCTL; i++) begin
        ctl_q[i]   <= '0;
        ctl_dly[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCTL; i++) begin
        if (reg_we_i && (word == (ADDR_W-2)'(i))) ctl_q[i] <= reg_wdata_i;
        ctl_dly[i] <= ctl_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      crcerr_q  <= 1'b0;
      resp_en_q <= 1'b0;
      long_q    <= 1'b0;
      frame_q   <= '0;
    end else if (abort_req) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      crcerr_q <= 1'b0;
    end else if (launch) begin
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      crcerr_q  <= 1'b0;
      resp_en_q <= ctl_q[CTL_SET][0];
      long_q    <= ctl_q[CTL_SET][1];
      frame_q   <= frame_w;
    end else if (busy_q && finish) begin
      busy_q   <= 1'b0;
      done_q   <= !rx_tmo;
      tmo_q    <= rx_tmo;
      crcerr_q <= rx_crc_bad;
    end
  end

  sd_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_q),
    .div_i   (ctl_q[CTL_DIV][DIV_W-1:0]),
    .sd_clk_o(sd_clk_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  sd_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .abort_i(abort_req),
    .frame_i(frame_w),
    .fall_i (fall),
    .cmd_o  (sd_cmd_o),
    .oe_o   (sd_cmd_oe_o),
    .done_o (tx_done)
  );

  sd_rsp_rx #(.TMO_W(TMO_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (launch),
    .arm_i    (tx_done && resp_en_q && !abort_req),
    .abort_i  (abort_req),
    .long_i   (long_q),
    .timeout_i(ctl_q[CTL_TMO][TMO_W-1:0]),
    .rise_i   (rise),
    .cmd_i    (sd_cmd_i),
    .done_o   (rx_done),
    .tmo_o    (rx_tmo),
    .crc_bad_o(rx_crc_bad),
    .rsp_o    (rsp),
    .wait_o   (wait_cnt)
  );

  always_comb begin
    reg_rdata_o = UNUSED_WORD;
    if ((word >= (ADDR_W-2)'(RB_WORD)) && (word < (ADDR_W-2)'(RB_WORD + NCTL))) begin
      reg_rdata_o = ctl_dly[32'(word) - RB_WORD];
    end else if (word < (ADDR_W-2)'(8)) begin
      case (word[2:0])
        3'd0: reg_rdata_o = rsp[38:7];
        3'd1: reg_rdata_o = rsp[70:39];
        3'd2: reg_rdata_o = rsp[102:71];
        3'd3: reg_rdata_o = {1'b0, rsp[133:103]};
        3'd4: reg_rdata_o = 32'(wait_cnt);
        3'd5: reg_rdata_o = {28'd0, crcerr_q, tmo_q, done_q, busy_q};
        3'd6: reg_rdata_o = frame_q[31:0];
        default: reg_rdata_o = {16'd0, frame_q[47:32]};
      endcase
    end
  end

  AST_OE_ONLY_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_cmd_oe_o |-> busy_q); // R2
  AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_q, done_q, tmo_q})); // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_req) |=> $stable(frame_q)); // R9
  AST_ABORT_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req |=> (!busy_q && !sd_cmd_oe_o)); // R10
  AST_CRCERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crcerr_q |-> done_q); // R8
endmodule

// File: tb/sim_sd_cmd_seq.sv
`timescale 1ns/1ps
module sim_sd_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sd_clk, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sd_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sd_clk_o(sd_clk),
    .sd_cmd_o(cmd_out), .sd_cmd_oe_o(cmd_oe), .sd_cmd_i(cmd_in)
  );

  typedef struct {
    string tag;
    logic [31:0] st, wt, flo, fhi, r0, r1, r2, r3;
  } exp_t;
  exp_t sb[$];
  event mon_go, mon_done;

  logic [47:0] wire_frame = '0;
  always @(posedge sd_clk) if (cmd_oe) wire_frame <= {wire_frame[46:0], cmd_out};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
    @(negedge clk);
  endtask

  function automatic logic [6:0] ref_crc(input logic [119:0] v, input int len);
    logic [6:0] c = '0;
    for (int i = len - 1; i >= 0; i--) begin
      logic top = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (top) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [119:0] v = '0;
    v[39:0] = {2'b01, idx, arg};
    return {2'b01, idx, arg, ref_crc(v, 40), 1'b1};
  endfunction

  task automatic card(input logic [135:0] r, input int n, input int k);
    @(negedge cmd_oe);
    repeat (k) @(posedge sd_clk);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge sd_clk);
      #1 cmd_in = r[i];
    end
    @(negedge sd_clk);
    #1 cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h14, s);
      if (!s[0]) break;
    end
  endtask

  // mode: 0 no reply, 1 short, 2 long; k < 0 means the card stays silent
  task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input int mode, input int k, input logic [31:0] tmo,
                         input logic [7:0] div, input bit bad, input logic [119:0] data);
    exp_t e;
    logic [47:0]  f;
    logic [135:0] r;
    logic [119:0] v;
    logic [6:0]   c;
    int n;
    longint t0, t1;
    f = ref_frame(idx, arg);
    r = '0; v = '0; n = 0;
    if (mode == 1) begin
      v[39:0] = {2'b00, idx, data[31:0]};
      c = ref_crc(v, 40) ^ (bad ? 7'h01 : 7'h00);
      r[47:0] = {v[39:0], c, 1'b1};
      n = 48;
    end else if (mode == 2) begin
      c = ref_crc(data, 120) ^ (bad ? 7'h01 : 7'h00);
      r = {2'b00, 6'h3F, data, c, 1'b1};
      n = 136;
    end
    e.tag = tag;
    e.flo = f[31:0];
    e.fhi = {16'd0, f[47:32]};
    if (mode == 0) begin
      e.st = 32'h2; e.wt = 0; r = '0;
    end else if (k < 0) begin
      e.st = 32'h4; e.wt = tmo; r = '0;
    end else begin
      e.st = bad ? 32'hA : 32'h2; e.wt = k;
    end
    e.r0 = r[38:7]; e.r1 = r[70:39]; e.r2 = r[102:71]; e.r3 = {1'b0, r[133:103]};
    wr(8'h00, arg);
    wr(8'h04, {26'd0, idx});
    wr(8'h08, (mode == 0) ? 32'h0 : (mode == 1) ? 32'h1 : 32'h3);
    wr(8'h1C, tmo);
    wr(8'h20, {24'd0, div});
    if (mode != 0 && k >= 0) fork card(r, n, k); join_none
    wr(8'h0C, 32'h1);
    @(posedge sd_clk); t0 = $time;
    @(posedge sd_clk); t1 = $time;
    check({"R2 period ", tag}, 32'(t1 - t0), 32'(20 * (int'(div) + 1)));
    @(negedge clk);
    wait_idle();
    sb.push_back(e);
    ->mon_go;
    @(mon_done);
  endtask

  initial begin
    forever begin
      exp_t e;
      logic [31:0] d;
      @(mon_go);
      e = sb.pop_front();
      rd(8'h14, d); check({"R3/R7/R8 status ", e.tag}, d, e.st);
      rd(8'h10, d); check({"R6 wait ", e.tag}, d, e.wt);
      rd(8'h18, d); check({"R1 frame lo ", e.tag}, d, e.flo);
      rd(8'h1C, d); check({"R1 frame hi ", e.tag}, d, e.fhi);
      check({"R2 wire lo ", e.tag}, wire_frame[31:0], e.flo);
      check({"R2 wire hi ", e.tag}, {16'd0, wire_frame[47:32]}, e.fhi);
      rd(8'h00, d); check({"R4/R5 rsp0 ", e.tag}, d, e.r0);
      rd(8'h04, d); check({"R4/R5 rsp1 ", e.tag}, d, e.r1);
      rd(8'h08, d); check({"R5 rsp2 ", e.tag}, d, e.r2);
      rd(8'h0C, d); check({"R5 rsp3 ", e.tag}, d, e.r3);
      ->mon_done;
    end
  end

  initial begin
    fork
      begin : main_seq
        logic [31:0] d;
        logic [47:0] fa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        rd(8'h14, d); check("R13 status", d, 32'h0);
        rd(8'h10, d); check("R13 wait", d, 32'h0);
        rd(8'h18, d); check("R13 frame", d, 32'h0);
        rd(8'h00, d); check("R13 rsp0", d, 32'h0);
        check("R13 sd_clk low", {31'd0, sd_clk}, 32'h0);
        check("R13 cmd released", {31'd0, cmd_oe}, 32'h0);
        // R12 unused addresses
        rd(8'h34, d); check("R12 unused 0x34", d, 32'hDEADBEEF);
        rd(8'hA0, d); check("R12 unused 0xA0", d, 32'hDEADBEEF);
        rd(8'h64, d); check("R12 unused 0x64", d, 32'hDEADBEEF);
        // R11 delayed readback
        wr(8'h1C, 32'h0000_1234);
        rd(8'h5C, d); check("R11 readback trails by one clock", d, 32'h0);
        rd(8'h5C, d); check("R11 readback timeout", d, 32'h0000_1234);
        wr(8'h14, 32'h0000_0007);
        wr(8'h18, 32'h0000_0200);
        rd(8'h54, d); check("R11 readback block count", d, 32'h7);
        rd(8'h58, d); check("R11 readback block size", d, 32'h200);
        // R1 literal frame for index 0, argument 0
        check("R1 literal crc", {16'd0, ref_frame(6'd0, 32'd0)[15:0]}, 32'h0000_0095);
        run_cmd("R3 no reply", 6'd0, 32'd0, 0, 0, 32'd64, 8'd1, 1'b0, '0);
        run_cmd("R4 short", 6'd8, 32'h0000_01AA, 1, 5, 32'd64, 8'd1, 1'b0,
                120'h0000_01AA);
        run_cmd("R8 bad crc", 6'd17, 32'h1234_5678, 1, 1, 32'd64, 8'd2, 1'b1,
                120'h0BAD_F00D);
        run_cmd("R5 long", 6'd2, 32'd0, 2, 3, 32'd64, 8'd0, 1'b0,
                120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32);
        run_cmd("R7 timeout", 6'd55, 32'h0000_ABCD, 1, -1, 32'd12, 8'd1, 1'b0, '0);
        // R9 start while busy
        wr(8'h00, 32'hCAFE_0001);
        wr(8'h04, 32'd17);
        wr(8'h08, 32'h1);
        wr(8'h1C, 32'd20);
        wr(8'h20, 32'd1);
        wr(8'h0C, 32'h1);
        repeat (5) @(negedge clk);
        wr(8'h00, 32'h0BAD_0002);
        wr(8'h0C, 32'h1);
        fa = ref_frame(6'd17, 32'hCAFE_0001);
        rd(8'h18, d); check("R9 frame kept while busy", d, fa[31:0]);
        wait_idle();
        rd(8'h14, d); check("R9 first command ran to timeout", d, 32'h4);
        rd(8'h10, d); check("R9 wait of first command", d, 32'd20);
        check("R9 wire frame is first", wire_frame[31:0], fa[31:0]);
        // R10 abort
        wr(8'h1C, 32'd100000);
        wr(8'h20, 32'd0);
        wr(8'h0C, 32'h1);
        repeat (150) @(negedge clk);
        rd(8'h14, d); check("R10 busy before abort", d, 32'h1);
        wr(8'h10, 32'h1);
        rd(8'h14, d); check("R10 status after abort", d, 32'h0);
        check("R10 cmd released", {31'd0, cmd_oe}, 32'h0);
        repeat (4) @(negedge clk);
        check("R10 sd_clk stopped", {31'd0, sd_clk}, 32'h0);
        run_cmd("R10 recovery", 6'd13, 32'h5555_0000, 1, 2, 32'd64, 8'd1, 1'b0,
                120'h0000_0900);
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule